// File: doc/BRIEF.md
# Strided Stream Transfer Engine

This block executes one transfer descriptor at a time. It moves data between a strided region of external memory and a packed local buffer. The descriptor gives a command, a start memory address, a stride, an element count, a local buffer base and a byte mask. Once the engine accepts the descriptor, it issues one memory request per element. The memory address grows by the stride after every accepted request. The local buffer pointer grows by one. A strided memory region is therefore gathered into consecutive buffer words, or scattered back out of them.

On a write command, each beat takes its data from the buffer word the pointer names. On a read command, the memory returns data one cycle after it accepts a request, and the engine stores that data into the buffer word the beat was issued for. A one-cycle completion pulse ends every valid transfer. A descriptor that breaks the alignment or length rules is refused with a one-cycle error pulse, and the memory sees no request.

Top module: `strided_stream_engine`

## Requirements
- R1: `desc_ready` is high only while the engine is idle. A descriptor is taken on a cycle with `desc_valid` and `desc_ready` both high. A valid descriptor drives `mem_req` high in the next cycle, and `mem_req` never rises while idle.
- R2: The first request of a transfer carries `desc_addr`. Every later request carries the previous request's address plus `desc_stride`, modulo 2^ADDR_W.
- R3: `mem_req` stays high from the first beat through the last accepted beat, with no idle cycle in between. While `mem_ready` is low, the address and buffer pointer hold their values.
- R4: `desc_cmd[1]` = 1 selects stream mode, which issues exactly `desc_len` beats. `desc_cmd[1]` = 0 selects single mode, which issues exactly one beat; in single mode `desc_len` and `desc_stride` are not checked and have no effect.
- R5: Beat k of a transfer presents `buf_raddr` = `desc_buf` + k, modulo 2^BUF_AW. On a write, `mem_wdata` equals `buf_rdata`.
- R6: On a read (`desc_cmd[0]` = 0), `buf_we` is high exactly in the cycle after a beat is accepted. In that cycle `buf_waddr` equals that beat's buffer pointer and `buf_wdata` equals `mem_rdata`.
- R7: `mem_we` equals `desc_cmd[0]` (1 = write) and `mem_mask` equals `desc_mask` on every beat of the transfer. Each `mem_mask` bit enables one byte of the data bus.
- R8: A stream descriptor is refused if its stride is not a multiple of 4, its length is 0, or its length is above MAX_LEN (1024). A refused descriptor produces `desc_err` high for one cycle, in the cycle after the handshake, issues no request, and leaves the engine idle.
- R9: `done` is high for exactly one cycle: the cycle after the last beat is accepted. `desc_ready` is low during that cycle and high in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Engine idle, descriptor can be taken |
| desc_cmd | input | 2 | Bit 0: 1 = write, 0 = read; bit 1: 1 = stream, 0 = single |
| desc_addr | input | ADDR_W | Start memory address |
| desc_stride | input | ADDR_W | Address increment per beat |
| desc_len | input | LEN_W | Element count in stream mode |
| desc_buf | input | BUF_AW | Local buffer base word |
| desc_mask | input | DATA_W/8 | Byte enables for every beat |
| desc_err | output | 1 | One-cycle pulse: descriptor refused |
| done | output | 1 | One-cycle pulse: transfer complete |
| mem_req | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_mask | output | DATA_W/8 | Request byte enables |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after acceptance |
| buf_raddr | output | BUF_AW | Buffer read address (combinational read) |
| buf_rdata | input | DATA_W | Buffer read data |
| buf_we | output | 1 | Buffer write enable |
| buf_waddr | output | BUF_AW | Buffer write address |
| buf_wdata | output | DATA_W | Buffer write data |

## Verification
The properties assume a memory with a fixed read latency of one cycle, a buffer whose read data follows `buf_raddr` within the same cycle, and a source that offers descriptors only while `desc_ready` is high. The bench models the memory and the buffer to match these assumptions. It changes `desc_valid` only at falling edges, and waits for completion or the error pulse before it offers the next descriptor. The random `mem_ready` density is kept at 30 % or higher, so that the 1024-beat transfers finish well inside the run.

// File: rtl/strided_stream_engine.sv
module strided_stream_engine #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int BUF_AW  = 10,
  parameter int MAX_LEN = 1024,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  desc_valid,
  output logic                  desc_ready,
  input  logic [1:0]            desc_cmd,
  input  logic [ADDR_W-1:0]     desc_addr,
  input  logic [ADDR_W-1:0]     desc_stride,
  input  logic [LEN_W-1:0]      desc_len,
  input  logic [BUF_AW-1:0]     desc_buf,
  input  logic [DATA_W/8-1:0]   desc_mask,
  output logic                  desc_err,
  output logic                  done,
  output logic                  mem_req,
  input  logic                  mem_ready,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W/8-1:0]   mem_mask,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic [BUF_AW-1:0]     buf_raddr,
  input  logic [DATA_W-1:0]     buf_rdata,
  output logic                  buf_we,
  output logic [BUF_AW-1:0]     buf_waddr,
  output logic [DATA_W-1:0]     buf_wdata
);
  localparam int MASK_W = DATA_W / 8;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t              st;
  logic [ADDR_W-1:0]   addr_q, stride_q;
  logic [LEN_W-1:0]    left_q;
  logic [BUF_AW-1:0]   ptr_q, rd_ptr_q;
  logic [MASK_W-1:0]   mask_q;
  logic                we_q, rd_pend_q, err_q;

  logic take, bad, beat, last;

  assign take = desc_valid && (st == S_IDLE);
  assign bad  = desc_cmd[1] && ((desc_stride[1:0] != 2'b00) || (desc_len == '0) ||
                                (desc_len > LEN_W'(MAX_LEN)));
  assign beat = (st == S_RUN) && mem_ready;
  assign last = (left_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr_q    <= '0;
      stride_q  <= '0;
      left_q    <= '0;
      ptr_q     <= '0;
      mask_q    <= '0;
      we_q      <= 1'b0;
      err_q     <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_ptr_q  <= '0;
    end else begin
      err_q     <= take && bad;
      rd_pend_q <= beat && !we_q;
      rd_ptr_q  <= ptr_q;
      case (st)
        S_IDLE: if (take && !bad) begin
          st       <= S_RUN;
          addr_q   <= desc_addr;
          stride_q <= desc_stride;
          left_q   <= desc_cmd[1] ? desc_len : LEN_W'(1);
          ptr_q    <= desc_buf;
          mask_q   <= desc_mask;
          we_q     <= desc_cmd[0];
        end
        S_RUN: if (mem_ready) begin
          addr_q <= addr_q + stride_q;
          ptr_q  <= ptr_q + BUF_AW'(1);
          left_q <= left_q - LEN_W'(1);
          if (last) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign desc_ready = (st == S_IDLE);
  assign desc_err   = err_q;
  assign done       = (st == S_FIN);
  assign mem_req    = (st == S_RUN);
  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_mask   = mask_q;
  assign mem_wdata  = buf_rdata;
  assign buf_raddr  = ptr_q;
  assign buf_we     = rd_pend_q;
  assign buf_waddr  = rd_ptr_q;
  assign buf_wdata  = mem_rdata;
endmodule

// File: rtl/strided_stream_engine_chk.sv
module strided_stream_engine_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int BUF_AW  = 10,
  parameter int MAX_LEN = 1024,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                desc_valid,
  input logic                desc_ready,
  input logic [1:0]          desc_cmd,
  input logic [ADDR_W-1:0]   desc_addr,
  input logic [ADDR_W-1:0]   desc_stride,
  input logic [LEN_W-1:0]    desc_len,
  input logic [BUF_AW-1:0]   desc_buf,
  input logic [DATA_W/8-1:0] desc_mask,
  input logic                desc_err,
  input logic                done,
  input logic                mem_req,
  input logic                mem_ready,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_mask,
  input logic [BUF_AW-1:0]   buf_raddr,
  input logic                buf_we,
  input logic [BUF_AW-1:0]   buf_waddr
);
  logic take, refuse;
  logic [ADDR_W-1:0] stride_c;
  logic [LEN_W-1:0]  len_c, cnt_c;

  assign take   = desc_valid && desc_ready;
  assign refuse = desc_cmd[1] && ((desc_stride[1:0] != 2'b00) || (desc_len == '0) ||
                                  (desc_len > LEN_W'(MAX_LEN)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stride_c <= '0;
      len_c    <= '0;
      cnt_c    <= '0;
    end else if (take) begin
      stride_c <= desc_stride;
      len_c    <= desc_cmd[1] ? desc_len : LEN_W'(1);
      cnt_c    <= '0;
    end else if (mem_req && mem_ready) begin
      cnt_c <= cnt_c + LEN_W'(1);
    end
  end

  assert_idle_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_ready && mem_req));
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !refuse |=> mem_req && mem_addr == $past(desc_addr) && buf_raddr == $past(desc_buf));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> !mem_req || mem_addr == $past(mem_addr) + stride_c);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(buf_raddr));
  assert_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready && !done |=> mem_req || done);
  assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt_c == len_c);
  assert_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> !mem_req || buf_raddr == $past(buf_raddr) + BUF_AW'(1));
  assert_rd_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready && !mem_we |=> buf_we && buf_waddr == $past(buf_raddr));
  assert_no_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_ready && !mem_we) |=> !buf_we);
  assert_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take && !refuse |=> mem_mask == $past(desc_mask) && mem_we == $past(desc_cmd[0]));
  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> $stable(mem_mask) && $stable(mem_we));
  assert_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && refuse |=> desc_err && !mem_req && desc_ready);
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |=> !desc_err);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && desc_ready);
  assert_done_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !desc_ready && $past(mem_req && mem_ready));
endmodule

bind strided_stream_engine strided_stream_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_AW(BUF_AW), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/test_strided_stream_engine.sv
`timescale 1ns/1ps
module test_strided_stream_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        desc_valid = 1'b0, desc_ready;
  logic [1:0]  desc_cmd = '0;
  logic [31:0] desc_addr = '0, desc_stride = '0;
  logic [10:0] desc_len = '0;
  logic [9:0]  desc_buf = '0;
  logic [7:0]  desc_mask = '0;
  logic        desc_err, done, mem_req, mem_ready = 1'b0, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_mask;
  logic [63:0] mem_wdata, mem_rdata = '0, buf_rdata, buf_wdata;
  logic [9:0]  buf_raddr, buf_waddr;
  logic        buf_we;

  logic [63:0] bufm [0:1023];
  assign buf_rdata = bufm[buf_raddr];

  always #2.5 clk = ~clk;

  strided_stream_engine i_strided_stream_engine (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_cmd(desc_cmd), .desc_addr(desc_addr), .desc_stride(desc_stride),
    .desc_len(desc_len), .desc_buf(desc_buf), .desc_mask(desc_mask),
    .desc_err(desc_err), .done(done), .mem_req(mem_req), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_mask(mem_mask), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata));

  int checks = 0, errors = 0, cycles = 0;
  logic        active = 1'b0, exp_we = 1'b0, done_seen = 1'b0;
  logic        exp_done = 1'b0, exp_bwe = 1'b0;
  logic [31:0] e_addr0 = '0, e_stride = '0;
  logic [9:0]  e_base = '0;
  logic [7:0]  e_mask = '0;
  int          e_n = 0, beat = 0, rd_idx = 0, ready_pct = 100;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_of(input int k);
    return e_addr0 + e_stride * 32'(k);
  endfunction

  function automatic logic [63:0] mem_word(input logic [31:0] a);
    return {a, a ^ 32'hA5A5_5A5A};
  endfunction

  function automatic logic [9:0] ptr_of(input int k);
    return e_base + 10'(k);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic nb;
      nb = 1'b0;
      chk(done === exp_done, "R9 done timing", 64'(done), 64'(exp_done));
      if (done) done_seen = 1'b1;
      exp_done = 1'b0;
      chk(buf_we === exp_bwe, "R6 buf_we", 64'(buf_we), 64'(exp_bwe));
      if (buf_we) begin
        chk(buf_waddr === ptr_of(rd_idx), "R6 buf_waddr", 64'(buf_waddr), 64'(ptr_of(rd_idx)));
        chk(buf_wdata === mem_word(addr_of(rd_idx)), "R6 buf_wdata", buf_wdata, mem_word(addr_of(rd_idx)));
        bufm[buf_waddr] = buf_wdata;
        rd_idx++;
      end
      mem_ready = (($urandom % 100) < 32'(ready_pct));
      if (mem_req) begin
        if (!active || beat >= e_n) chk(1'b0, "R4 extra request", 64'(beat), 64'(e_n));
        else begin
          chk(mem_addr === addr_of(beat), "R2 R3 mem_addr", 64'(mem_addr), 64'(addr_of(beat)));
          chk(buf_raddr === ptr_of(beat), "R5 buf_raddr", 64'(buf_raddr), 64'(ptr_of(beat)));
          chk(mem_we === exp_we && mem_mask === e_mask, "R7 we/mask",
              {55'd0, mem_we, mem_mask}, {55'd0, exp_we, e_mask});
          if (exp_we) chk(mem_wdata === bufm[ptr_of(beat)], "R5 mem_wdata", mem_wdata, bufm[ptr_of(beat)]);
          if (mem_ready) begin
            if (!exp_we) begin
              nb = 1'b1;
              mem_rdata = mem_word(mem_addr);
            end
            beat++;
            if (beat == e_n) exp_done = 1'b1;
          end
        end
      end
      exp_bwe = nb;
    end
  end

  task automatic run(input logic [1:0] cmd, input logic [31:0] a, input logic [31:0] s,
                     input logic [10:0] len, input logic [9:0] base, input logic [7:0] m, input int pct);
    int wait_n;
    @(negedge clk); #1;
    chk(desc_ready === 1'b1, "R1 ready when idle", 64'(desc_ready), 64'd1);
    e_addr0 = a; e_stride = s; e_base = base; e_mask = m; exp_we = cmd[0];
    e_n = cmd[1] ? int'(len) : 1;
    beat = 0; rd_idx = 0; done_seen = 1'b0; ready_pct = pct; active = 1'b1;
    if (cmd[0]) for (int k = 0; k < e_n; k++) bufm[ptr_of(k)] = {$urandom, $urandom};
    desc_cmd = cmd; desc_addr = a; desc_stride = s; desc_len = len; desc_buf = base; desc_mask = m;
    desc_valid = 1'b1;
    @(negedge clk); #1;
    desc_valid = 1'b0;
    chk(mem_req === 1'b1 && desc_ready === 1'b0, "R1 request after handshake",
        {62'd0, mem_req, desc_ready}, 64'd2);
    wait_n = 0;
    while (!done_seen && wait_n < 8000) begin
      @(negedge clk); #1;
      wait_n++;
    end
    chk(done_seen && beat == e_n, "R4 R9 transfer completes", 64'(beat), 64'(e_n));
    chk(desc_ready === 1'b0, "R9 ready low in done cycle", 64'(desc_ready), 64'd0);
    @(negedge clk); #1;
    chk(desc_ready === 1'b1 && done === 1'b0, "R9 idle after done", {62'd0, desc_ready, done}, 64'd2);
    if (!cmd[0]) chk(rd_idx == e_n, "R6 all read beats stored", 64'(rd_idx), 64'(e_n));
    active = 1'b0;
  endtask

  task automatic refuse(input logic [31:0] s, input logic [10:0] len);
    @(negedge clk); #1;
    desc_cmd = 2'b11; desc_addr = 32'h100; desc_stride = s; desc_len = len; desc_valid = 1'b1;
    active = 1'b0;
    @(negedge clk); #1;
    desc_valid = 1'b0;
    chk(desc_err === 1'b1 && mem_req === 1'b0, "R8 error pulse", {62'd0, desc_err, mem_req}, 64'd2);
    chk(desc_ready === 1'b1, "R8 stays idle", 64'(desc_ready), 64'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(desc_err === 1'b0 && mem_req === 1'b0, "R8 no request after refusal",
          {62'd0, desc_err, mem_req}, 64'd0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) bufm[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(desc_ready === 1'b1 && mem_req === 1'b0 && done === 1'b0 && desc_err === 1'b0,
        "R1 reset state", {60'd0, desc_ready, mem_req, done, desc_err}, 64'h8);

    run(2'b11, 32'h0000_1000, 32'd4, 11'd8, 10'd0, 8'hFF, 100);
    run(2'b10, 32'h0000_2000, 32'd128, 11'd8, 10'd16, 8'hFF, 100);
    run(2'b01, 32'h0000_3004, 32'd3, 11'd0, 10'd40, 8'h0F, 100);
    run(2'b00, 32'h0000_4000, 32'd7, 11'd2000, 10'd41, 8'hF0, 60);
    run(2'b11, 32'h0001_0000, 32'd4, 11'd1024, 10'd512, 8'hFF, 100);
    run(2'b10, 32'h0002_0000, 32'd8, 11'd1024, 10'd1000, 8'h3C, 70);
    run(2'b10, 32'h0000_5000, 32'd0, 11'd5, 10'd100, 8'h01, 40);
    run(2'b11, 32'h0000_0010, 32'hFFFF_FFF8, 11'd6, 10'd1020, 8'hAA, 50);
    run(2'b11, 32'h0000_6000, 32'd12, 11'd1, 10'd7, 8'h81, 30);

    refuse(32'd6, 11'd4);
    refuse(32'd4, 11'd0);
    refuse(32'd4, 11'd1025);
    refuse(32'd1, 11'd2047);

    for (int it = 0; it < 40; it++) begin
      logic [1:0] c;
      c = {($urandom % 5) != 0, 1'($urandom)};
      run(c, $urandom, {24'd0, 6'($urandom), 2'b00}, 11'(1 + $urandom % 64),
          10'($urandom), 8'($urandom), 30 + int'($urandom % 71));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule